// File: doc/BRIEF.md
# Dataflow Reservation Station

This block holds renamed instructions until their operands exist, then hands them to a single functional unit. An instruction enters through the insert port with an opcode, a destination tag and two source operands. Each operand either arrives with its value or names the tag of the instruction that will produce it. Instructions that depend on results not yet computed wait here, and instructions whose inputs are already known go on ahead of them.

When a producer finishes, its tag and result are driven onto the broadcast port. Every stored entry compares that tag against each of its waiting operands in the same cycle and takes the value where they match. An operand arriving on the insert port in the same cycle as a broadcast is compared as well. Entries with every operand present request dispatch. If several are eligible, an age order kept per entry picks the one that was inserted first. The dispatch port uses a valid/ready handshake, and an entry is released in the cycle that handshake completes.

Top module: `rs_station`

## Requirements
- R1: After synchronous reset no entry is occupied: `ins_ready` is 1 and `dp_valid` is 0.
- R2: An insert is taken when `ins_valid` and `ins_ready` are both 1 at a clock edge. An instruction whose two operands are both marked ready appears on the dispatch port right after that edge, carrying its opcode, destination tag and stored values (source 0 on `dp_s0_val`, source 1 on `dp_s1_val`).
- R3: A broadcast (`bc_valid` 1) whose tag equals the tag of a waiting operand marks that operand ready and stores `bc_val` into it. Other waiting operands of the same entry, with different tags, keep waiting.
- R4: A broadcast in the same cycle as an accepted insert is compared against the incoming operands, so a match is captured without a second broadcast.
- R5: `dp_valid` is 1 only while some occupied entry has both operands ready. An entry with a waiting operand is never offered.
- R6: When several entries are eligible, the one accepted earliest is offered on the dispatch port.
- R7: With all DEPTH entries occupied, `ins_ready` is 0. An insert attempted then is dropped and never reaches the dispatch port.
- R8: A broadcast whose tag equals the tag field of an operand already marked ready leaves that operand's value unchanged.
- R9: An entry is released in the cycle its handshake (`dp_valid` and `dp_ready`) completes. While `dp_ready` is 0, `dp_valid` stays 1.
- R10: A younger instruction with ready operands is dispatched ahead of an older one that is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | A free entry exists |
| ins_op | input | OP_W | Opcode of the inserted instruction |
| ins_dst_tag | input | TAG_W | Tag the instruction's result will carry |
| ins_s0_rdy | input | 1 | Source 0 value is present |
| ins_s0_tag | input | TAG_W | Producer tag of source 0 |
| ins_s0_val | input | DATA_W | Value of source 0 |
| ins_s1_rdy | input | 1 | Source 1 value is present |
| ins_s1_tag | input | TAG_W | Producer tag of source 1 |
| ins_s1_val | input | DATA_W | Value of source 1 |
| bc_valid | input | 1 | Result broadcast is valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| dp_valid | output | 1 | An instruction is offered to the functional unit |
| dp_ready | input | 1 | Functional unit accepts the offer |
| dp_op | output | OP_W | Opcode offered |
| dp_dst_tag | output | TAG_W | Destination tag offered |
| dp_s0_val | output | DATA_W | Source 0 value offered |
| dp_s1_val | output | DATA_W | Source 1 value offered |

## Verification
The bench fills the station with a mix of waiting and ready entries while dispatch is held off. Broadcasts then wake them in an order other than insert order, which exposes a picker that follows slot index or wakeup order instead of age. A broadcast in the same cycle as an insert targets a design that checks only stored entries; that design would leave the new instruction waiting forever. A broadcast whose tag also appears on an already ready operand catches comparators that ignore the ready flag and overwrite a good value. A refused insert while full shows whether a design that wrongly writes into an occupied slot lets an extra instruction leak onto the dispatch port.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int TAG_W     = 4;
    parameter int DATA_W    = 16;
    parameter int OP_W      = 4;
    parameter int NSRC      = 2;
    parameter int RS_DEPTH  = 4;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } opnd_t;

    typedef struct packed {
        op_t               op;
        tag_t              dst;
        opnd_t [NSRC-1:0]  src;
    } rs_instr_t;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        data_t val;
    } bcast_t;

    function automatic logic tag_hit(input opnd_t o, input bcast_t b);
        return b.vld && !o.rdy && (o.tag == b.tag);
    endfunction
endpackage

// File: rtl/rs_src_capture.sv
module rs_src_capture
    import rs_pkg::*;
(
    input  opnd_t  in_op,
    input  bcast_t bc,
    output opnd_t  out_op
);
    always_comb begin
        out_op = in_op;
        if (tag_hit(in_op, bc)) begin
            out_op.rdy = 1'b1;
            out_op.val = bc.val;
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int AGE_W = 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  rs_instr_t        load_instr,
    input  logic [AGE_W-1:0] load_age,
    input  logic             clear,
    input  logic             age_dec,
    input  bcast_t           bc,
    output logic             valid,
    output rs_instr_t        instr,
    output logic [AGE_W-1:0] age,
    output logic             all_rdy
);
    rs_instr_t woke;
    logic [NSRC-1:0] rdy_vec;

    always_comb begin
        woke.op  = instr.op;
        woke.dst = instr.dst;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rs_src_capture u_cap (
            .in_op  (instr.src[s]),
            .bc     (bc),
            .out_op (woke.src[s])
        );
        assign rdy_vec[s] = instr.src[s].rdy;
    end

    assign all_rdy = valid && (&rdy_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            instr <= '0;
            age   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            instr <= load_instr;
            age   <= load_age;
        end else begin
            if (clear) begin
                valid <= 1'b0;
            end
            instr <= woke;
            if (age_dec) begin
                age <= age - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N     = 4,
    parameter int AGE_W = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
    input  logic [N-1:0]     req,
    input  logic [AGE_W-1:0] age [N],
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    for (genvar i = 0; i < N; i++) begin : g_win
        logic w;
        always_comb begin
            w = req[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && !(age[i] < age[j])) begin
                    w = 1'b0;
                end
            end
        end
        assign grant[i] = w;
    end

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) begin
                idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DEPTH = RS_DEPTH
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [TAG_W-1:0]  ins_dst_tag,
    input  logic              ins_s0_rdy,
    input  logic [TAG_W-1:0]  ins_s0_tag,
    input  logic [DATA_W-1:0] ins_s0_val,
    input  logic              ins_s1_rdy,
    input  logic [TAG_W-1:0]  ins_s1_tag,
    input  logic [DATA_W-1:0] ins_s1_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              dp_valid,
    input  logic              dp_ready,
    output logic [OP_W-1:0]   dp_op,
    output logic [TAG_W-1:0]  dp_dst_tag,
    output logic [DATA_W-1:0] dp_s0_val,
    output logic [DATA_W-1:0] dp_s1_val
);
    localparam int AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    bcast_t     bc;
    rs_instr_t  ins_raw;
    rs_instr_t  ins_woke;

    logic [DEPTH-1:0] ent_vld;
    logic [DEPTH-1:0] ent_rdy;
    logic [DEPTH-1:0] grant;
    rs_instr_t        ent_instr [DEPTH];
    logic [AGE_W-1:0] ent_age   [DEPTH];

    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic [CNT_W-1:0] occ_cnt;
    logic [CNT_W-1:0] new_age_full;
    logic             accept;
    logic             fire;

    assign bc = '{vld: bc_valid, tag: bc_tag, val: bc_val};

    always_comb begin
        ins_raw.op  = ins_op;
        ins_raw.dst = ins_dst_tag;
        ins_raw.src[0] = '{rdy: ins_s0_rdy, tag: ins_s0_tag, val: ins_s0_val};
        ins_raw.src[1] = '{rdy: ins_s1_rdy, tag: ins_s1_tag, val: ins_s1_val};
        ins_woke.op  = ins_raw.op;
        ins_woke.dst = ins_raw.dst;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_ins_cap
        rs_src_capture u_cap (
            .in_op  (ins_raw.src[s]),
            .bc     (bc),
            .out_op (ins_woke.src[s])
        );
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        occ_cnt  = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (!ent_vld[k]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(k);
            end
            occ_cnt = occ_cnt + CNT_W'(ent_vld[k]);
        end
    end

    assign ins_ready    = free_any;
    assign accept       = ins_valid && ins_ready;
    assign fire         = dp_valid && dp_ready;
    assign new_age_full = occ_cnt - CNT_W'(fire);

    rs_age_pick #(
        .N     (DEPTH),
        .AGE_W (AGE_W)
    ) u_pick (
        .req   (ent_rdy),
        .age   (ent_age),
        .grant (grant),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic do_load;
        logic do_clear;
        logic do_dec;
        assign do_load  = accept && (free_idx == IDX_W'(i));
        assign do_clear = fire && grant[i];
        assign do_dec   = fire && ent_vld[i] && (ent_age[i] > ent_age[pick_idx]);

        rs_slot #(
            .AGE_W (AGE_W)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .load       (do_load),
            .load_instr (ins_woke),
            .load_age   (new_age_full[AGE_W-1:0]),
            .clear      (do_clear),
            .age_dec    (do_dec),
            .bc         (bc),
            .valid      (ent_vld[i]),
            .instr      (ent_instr[i]),
            .age        (ent_age[i]),
            .all_rdy    (ent_rdy[i])
        );
    end

    assign dp_valid   = pick_any;
    assign dp_op      = ent_instr[pick_idx].op;
    assign dp_dst_tag = ent_instr[pick_idx].dst;
    assign dp_s0_val  = ent_instr[pick_idx].src[0].val;
    assign dp_s1_val  = ent_instr[pick_idx].src[1].val;
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int DEPTH = 4
)(
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             dp_valid,
    input logic             dp_ready,
    input logic [DEPTH-1:0] ent_vld
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occ;
    logic             rst_d;
    logic             acc;
    logic             dsp;

    assign acc = ins_valid && ins_ready;
    assign dsp = dp_valid && dp_ready;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= occ + CNT_W'(acc) - CNT_W'(dsp);
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (ins_ready && !dp_valid));

    // R7
    a_r7_occ_tracks: assert property (@(posedge clk) disable iff (rst)
        $countones(ent_vld) == int'(occ));

    // R7
    a_r7_full_refuse: assert property (@(posedge clk) disable iff (rst)
        (int'(occ) == DEPTH) |-> !ins_ready);

    // R9
    a_r9_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (dp_valid && !dp_ready) |=> dp_valid);

    // R9
    a_r9_free_one: assert property (@(posedge clk) disable iff (rst)
        (dsp && !acc) |=> ($countones(ent_vld) == $past($countones(ent_vld)) - 1));

    // R5
    a_r5_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        (ent_vld == '0) |-> !dp_valid);
endmodule

bind rs_station rs_station_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .dp_valid  (dp_valid),
    .dp_ready  (dp_ready),
    .ent_vld   (ent_vld)
);

// File: tb/rs_station_tb.sv
module rs_station_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [3:0]  ins_op = '0;
    logic [3:0]  ins_dst_tag = '0;
    logic        ins_s0_rdy = 1'b0;
    logic [3:0]  ins_s0_tag = '0;
    logic [15:0] ins_s0_val = '0;
    logic        ins_s1_rdy = 1'b0;
    logic [3:0]  ins_s1_tag = '0;
    logic [15:0] ins_s1_val = '0;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [15:0] bc_val = '0;
    logic        dp_valid;
    logic        dp_ready = 1'b0;
    logic [3:0]  dp_op;
    logic [3:0]  dp_dst_tag;
    logic [15:0] dp_s0_val;
    logic [15:0] dp_s1_val;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  dst;
        logic [15:0] v0;
        logic [15:0] v1;
    } exp_t;

    exp_t  exp_q [$];
    string req_q [$];

    always #5 clk = ~clk;

    rs_station u_dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_op(ins_op), .ins_dst_tag(ins_dst_tag),
        .ins_s0_rdy(ins_s0_rdy), .ins_s0_tag(ins_s0_tag), .ins_s0_val(ins_s0_val),
        .ins_s1_rdy(ins_s1_rdy), .ins_s1_tag(ins_s1_tag), .ins_s1_val(ins_s1_val),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .dp_valid(dp_valid), .dp_ready(dp_ready),
        .dp_op(dp_op), .dp_dst_tag(dp_dst_tag),
        .dp_s0_val(dp_s0_val), .dp_s1_val(dp_s1_val)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] op, input logic [3:0] dst,
                        input logic [15:0] v0, input logic [15:0] v1, input string req);
        exp_q.push_back('{op: op, dst: dst, v0: v0, v1: v1});
        req_q.push_back(req);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic insert(input logic [3:0] op, input logic [3:0] dst,
                          input logic r0, input logic [3:0] t0, input logic [15:0] v0,
                          input logic r1, input logic [3:0] t1, input logic [15:0] v1);
        ins_valid = 1'b1; ins_op = op; ins_dst_tag = dst;
        ins_s0_rdy = r0; ins_s0_tag = t0; ins_s0_val = v0;
        ins_s1_rdy = r1; ins_s1_tag = t1; ins_s1_val = v1;
        step();
        ins_valid = 1'b0;
    endtask

    task automatic bcast(input logic [3:0] tag, input logic [15:0] val);
        bc_valid = 1'b1; bc_tag = tag; bc_val = val;
        step();
        bc_valid = 1'b0;
    endtask

    // Monitor: every completed handshake is compared with the head of the queue
    always @(negedge clk) begin
        if (!rst && dp_valid && dp_ready) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R7 unexpected dispatch actual=%0h expected=none", dp_op);
            end else begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check({r, " op"},  int'(dp_op),      int'(e.op));
                check({r, " dst"}, int'(dp_dst_tag), int'(e.dst));
                check({r, " s0"},  int'(dp_s0_val),  int'(e.v0));
                check({r, " s1"},  int'(dp_s1_val),  int'(e.v1));
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 ins_ready", int'(ins_ready), 1);
        check("R1 dp_valid", int'(dp_valid), 0);

        // R2: ready-at-insert instruction dispatches the next cycle
        step();
        dp_ready = 1'b1;
        push(4'h1, 4'hA, 16'h1234, 16'h5678, "R2");
        insert(4'h1, 4'hA, 1'b1, 4'h0, 16'h1234, 1'b1, 4'h0, 16'h5678);
        @(negedge clk);
        check("R2 dp_valid", int'(dp_valid), 1);
        repeat (2) step();

        // R7/R6/R3: fill with dispatch held off
        dp_ready = 1'b0;
        insert(4'h1, 4'h8, 1'b0, 4'h1, 16'h0000, 1'b1, 4'h0, 16'h00E0);
        insert(4'h2, 4'h9, 1'b1, 4'h0, 16'h00E1, 1'b0, 4'h2, 16'h0000);
        insert(4'h3, 4'hB, 1'b0, 4'h3, 16'h0000, 1'b0, 4'h1, 16'h0000);
        insert(4'h4, 4'hC, 1'b1, 4'h0, 16'h0E30, 1'b1, 4'h0, 16'h0E31);
        @(negedge clk);
        check("R7 ins_ready when full", int'(ins_ready), 0);
        check("R5 only ready entry offered", int'(dp_op), 4);
        step();
        insert(4'h9, 4'hF, 1'b1, 4'h0, 16'hDEAD, 1'b1, 4'h0, 16'hBEEF);
        @(negedge clk);
        check("R9 offer held while stalled", int'(dp_valid), 1);
        step();
        bcast(4'h2, 16'h0022);
        bcast(4'h1, 16'h0011);
        @(negedge clk);
        check("R6 oldest ready offered", int'(dp_op), 1);
        push(4'h1, 4'h8, 16'h0011, 16'h00E0, "R6");
        push(4'h2, 4'h9, 16'h00E1, 16'h0022, "R6");
        push(4'h4, 4'hC, 16'h0E30, 16'h0E31, "R6");
        step();
        dp_ready = 1'b1;
        repeat (5) step();
        @(negedge clk);
        check("R3 partly woken entry waits", int'(dp_valid), 0);
        step();
        push(4'h3, 4'hB, 16'h0033, 16'h0011, "R3");
        bcast(4'h3, 16'h0033);
        repeat (3) step();
        @(negedge clk);
        check("R7 refused insert absent", int'(dp_valid), 0);
        check("R9 entries released", int'(ins_ready), 1);
        step();

        // R10: younger ready one bypasses older waiting one
        push(4'h6, 4'h2, 16'h0606, 16'h0607, "R10");
        insert(4'h5, 4'h1, 1'b0, 4'h4, 16'h0000, 1'b1, 4'h0, 16'h0505);
        insert(4'h6, 4'h2, 1'b1, 4'h0, 16'h0606, 1'b1, 4'h0, 16'h0607);
        repeat (2) step();
        @(negedge clk);
        check("R5 waiting entry not offered", int'(dp_valid), 0);
        step();
        push(4'h5, 4'h1, 16'h0444, 16'h0505, "R10");
        bcast(4'h4, 16'h0444);
        repeat (3) step();

        // R4: broadcast in the same cycle as insert
        push(4'h7, 4'h3, 16'h0066, 16'h0001, "R4");
        bc_valid = 1'b1; bc_tag = 4'h6; bc_val = 16'h0066;
        insert(4'h7, 4'h3, 1'b0, 4'h6, 16'h0000, 1'b1, 4'h0, 16'h0001);
        bc_valid = 1'b0;
        repeat (3) step();
        @(negedge clk);
        check("R4 woken at insert drained", int'(dp_valid), 0);
        step();

        // R8: broadcast matching a ready operand's tag field
        dp_ready = 1'b0;
        insert(4'h8, 4'h4, 1'b1, 4'h7, 16'h00AA, 1'b0, 4'h7, 16'h0000);
        @(negedge clk);
        check("R5 pending entry idle", int'(dp_valid), 0);
        step();
        push(4'h8, 4'h4, 16'h00AA, 16'h0077, "R8");
        bcast(4'h7, 16'h0077);
        dp_ready = 1'b1;
        repeat (3) step();

        @(negedge clk);
        check("R9 final ins_ready", int'(ins_ready), 1);
        check("R2 all expected dispatched", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            summary();
        end
    end
endmodule